// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is one direction of a two-way buffered link between two synchronous ports running on unrelated clocks. The write port stores 18-bit words on its own clock, and the read port drains them in arrival order on a second, independent clock. Storage depth is set by a parameter: 256 or 512 words. Write and read pointers cross between the clock domains in Gray code, each through a two-flop synchronizer.

Four active-low status conditions report the fill level: empty, almost-empty, almost-full and full. The almost-empty level n and the almost-full level m come from two offset registers. Both registers reset to 8 and are loaded from the write port. Each domain computes every threshold it drives from its own pointer and the synchronized copy of the other pointer. The read side therefore asserts empty and almost-empty at once, and the write side asserts full and almost-full at once. A flag in either domain releases only after the opposite pointer has been synchronized. The almost-empty and almost-full levels are driven in both domains, so each port sees them on its own clock.

Offsets are quasi-static. They are loaded while both ports are idle, and the read-domain comparators use them without resynchronization.

Top module: `xclk_flag_fifo`

## Requirements
- R1: Words leave in the order they were accepted. A read accepted at a rising edge of rclk_i presents its word on rd_data_o from that edge on, and rd_data_o holds its value at every other edge.
- R2: While rst_ni is low, both pointers clear, both offsets become 8 and rd_data_o becomes 0. After reset, empty_no, aempty_r_no and aempty_w_no are low, and afull_r_no, afull_w_no and full_no are high.
- R3: A write requested while full_no is low is ignored. The write pointer does not move, and no word is lost or duplicated.
- R4: A read requested while empty_no is low is ignored. The read pointer does not move and rd_data_o keeps its value.
- R5: Once both ports have been idle for 8 rclk_i cycles, empty_no is low exactly when 0 words are stored.
- R6: Once both ports have been idle for 8 rclk_i cycles, aempty_r_no and aempty_w_no are both low exactly when the stored count is at most n.
- R7: Once both ports have been idle for 8 rclk_i cycles, afull_r_no and afull_w_no are both low exactly when the stored count is at least D-m, where D is DEPTH.
- R8: Once both ports have been idle for 8 rclk_i cycles, full_no is low exactly when D words are stored.
- R9: During traffic the flags err only on the safe side.
  - empty_no is low whenever the FIFO holds nothing.
  - aempty_r_no is low whenever the count is at most n.
  - full_no is low whenever the FIFO holds D words.
  - afull_w_no is low whenever the count is at least D-m.
  - aempty_w_no is low only when the count is at most n.
  - afull_r_no is low only when the count is at least D-m.
- R10: At a rising edge of wclk_i with off_we_i high, off_val_i is loaded into the almost-empty offset when off_sel_i is 0, and into the almost-full offset when off_sel_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-port clock |
| rclk_i | input | 1 | Read-port clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Write request, sampled on wclk_i |
| wr_data_i | input | WIDTH | Word to store |
| off_we_i | input | 1 | Offset load strobe (wclk_i domain) |
| off_sel_i | input | 1 | Offset select: 0 almost-empty, 1 almost-full |
| off_val_i | input | log2(DEPTH) | Offset value to load |
| full_no | output | 1 | Full, active low, wclk_i domain |
| afull_w_no | output | 1 | Almost-full, active low, wclk_i domain |
| aempty_w_no | output | 1 | Almost-empty, active low, wclk_i domain |
| rd_en_i | input | 1 | Read request, sampled on rclk_i |
| rd_data_o | output | WIDTH | Registered read word |
| empty_no | output | 1 | Empty, active low, rclk_i domain |
| aempty_r_no | output | 1 | Almost-empty, active low, rclk_i domain |
| afull_r_no | output | 1 | Almost-full, active low, rclk_i domain |

## Verification
The hardest case to reach is a flag crossing a threshold while both pointers are moving. In that case each domain's view of the count lags the true count by an amount that depends on clock phase. The bench runs the two clocks at coprime periods and uses bursts with uneven enable rates. These bursts fill the FIFO to full and drain it to empty while a behavioural queue is checked on every edge of both clocks against the one-sided bounds. Exact threshold boundaries are checked separately once the ports are idle, for both the reset offsets and loaded offsets.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;
  localparam int unsigned WORD_W      = 18;
  localparam int unsigned OFF_DEFAULT = 8;

  typedef enum logic {
    SEL_AEMPTY = 1'b0,
    SEL_AFULL  = 1'b1
  } off_sel_e;
endpackage

// File: rtl/xfifo_sync.sv
`timescale 1ns/1ps
module xfifo_sync #(
  parameter int unsigned W      = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= g_stage[s-1].q;
    end
  end

  assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/xfifo_ptr.sv
`timescale 1ns/1ps
module xfifo_ptr #(
  parameter int unsigned PW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [PW-1:0] bin_o,
  output logic [PW-1:0] gray_o
);
  logic [PW-1:0] bin_d;

  assign bin_d = bin_o + {{(PW-1){1'b0}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_o  <= '0;
      gray_o <= '0;
    end else begin
      bin_o  <= bin_d;
      gray_o <= bin_d ^ (bin_d >> 1);
    end
  end

  // a crossing pointer may only flip one bit per edge (R9 depends on it)
  p_gray_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(gray_o ^ $past(gray_o)) <= 1);
endmodule

// File: rtl/xfifo_flags.sv
`timescale 1ns/1ps
module xfifo_flags #(
  parameter int unsigned AW         = 8,
  parameter bit          WRITE_SIDE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW:0]   own_bin_i,
  input  logic [AW:0]   peer_gray_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic [AW-1:0] af_off_i,
  output logic          edge_no,
  output logic          ae_no,
  output logic          af_no
);
  localparam int unsigned CW      = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = {1'b1, {AW{1'b0}}};

  logic [CW-1:0] peer_bin;
  logic [CW-1:0] count;

  always_comb begin
    for (int i = 0; i < CW; i++) peer_bin[i] = ^(peer_gray_i >> i);
  end

  if (WRITE_SIDE) begin : g_wr
    // own pointer is current, peer lags: count never under-reports
    assign count   = own_bin_i - peer_bin;
    assign edge_no = ~(count == DEPTH_C);
    p_full_in_afull_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !edge_no |-> !af_no);
  end else begin : g_rd
    // peer pointer lags: count never over-reports
    assign count   = peer_bin - own_bin_i;
    assign edge_no = ~(count == '0);
    p_empty_in_aempty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !edge_no |-> !ae_no);
  end

  assign ae_no = ~(count <= {1'b0, ae_off_i});
  assign af_no = ~(count >= (DEPTH_C - {1'b0, af_off_i}));

  p_count_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= DEPTH_C);
endmodule

// File: rtl/xfifo_mem.sv
`timescale 1ns/1ps
module xfifo_mem #(
  parameter int unsigned W  = 18,
  parameter int unsigned AW = 8
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int unsigned WORDS = 1 << AW;

  logic [W-1:0] mem_q [WORDS];

  always_ff @(posedge wclk_i)
    if (we_i) mem_q[waddr_i] <= wdata_i;

  always_ff @(posedge rclk_i or negedge rst_ni)
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
endmodule

// File: rtl/xclk_flag_fifo.sv
`timescale 1ns/1ps
module xclk_flag_fifo
  import xfifo_pkg::*;
#(
  parameter int unsigned DEPTH       = 256,
  parameter int unsigned WIDTH       = WORD_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned AW          = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             off_we_i,
  input  logic             off_sel_i,
  input  logic [AW-1:0]    off_val_i,
  output logic             full_no,
  output logic             afull_w_no,
  output logic             aempty_w_no,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_no,
  output logic             aempty_r_no,
  output logic             afull_r_no
);
  localparam int unsigned PW = AW + 1;

  logic [AW-1:0] ae_off_q, af_off_q;
  logic [PW-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [PW-1:0] wgray_in_r, rgray_in_w;
  logic          wr_go, rd_go;

  // offsets: quasi-static, written from the write port only while idle
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_off_q <= AW'(OFF_DEFAULT);
      af_off_q <= AW'(OFF_DEFAULT);
    end else if (off_we_i) begin
      if (off_sel_e'(off_sel_i) == SEL_AFULL) af_off_q <= off_val_i;
      else                                    ae_off_q <= off_val_i;
    end
  end

  assign wr_go = wr_en_i & full_no;
  assign rd_go = rd_en_i & empty_no;

  xfifo_ptr #(.PW(PW)) u_wptr (
    .clk_i (wclk_i), .rst_ni(rst_ni), .inc_i(wr_go),
    .bin_o (wptr_bin), .gray_o(wptr_gray)
  );

  xfifo_ptr #(.PW(PW)) u_rptr (
    .clk_i (rclk_i), .rst_ni(rst_ni), .inc_i(rd_go),
    .bin_o (rptr_bin), .gray_o(rptr_gray)
  );

  xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wptr_gray), .q_o(wgray_in_r)
  );

  xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rptr_gray), .q_o(rgray_in_w)
  );

  xfifo_flags #(.AW(AW), .WRITE_SIDE(1'b1)) u_wflags (
    .clk_i      (wclk_i),
    .rst_ni     (rst_ni),
    .own_bin_i  (wptr_bin),
    .peer_gray_i(rgray_in_w),
    .ae_off_i   (ae_off_q),
    .af_off_i   (af_off_q),
    .edge_no    (full_no),
    .ae_no      (aempty_w_no),
    .af_no      (afull_w_no)
  );

  xfifo_flags #(.AW(AW), .WRITE_SIDE(1'b0)) u_rflags (
    .clk_i      (rclk_i),
    .rst_ni     (rst_ni),
    .own_bin_i  (rptr_bin),
    .peer_gray_i(wgray_in_r),
    .ae_off_i   (ae_off_q),
    .af_off_i   (af_off_q),
    .edge_no    (empty_no),
    .ae_no      (aempty_r_no),
    .af_no      (afull_r_no)
  );

  xfifo_mem #(.W(WIDTH), .AW(AW)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (wr_go),
    .waddr_i(wptr_bin[AW-1:0]),
    .wdata_i(wr_data_i),
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .re_i   (rd_go),
    .raddr_i(rptr_bin[AW-1:0]),
    .rdata_o(rd_data_o)
  );

  p_no_overflow_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_en_i && !full_no) |=> $stable(wptr_bin));

  p_no_underflow_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_en_i && !empty_no) |=> ($stable(rptr_bin) && $stable(rd_data_o)));

  p_hold_data_r1: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  p_offset_load_r10: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (off_we_i && off_sel_i) |=> (af_off_q == $past(off_val_i)));
endmodule

// File: tb/xclk_flag_fifo_bench.sv
`timescale 1ns/1ps
module xclk_flag_fifo_bench;
  localparam int D  = 256;
  localparam int AW = 8;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  always #2.5 wclk = ~wclk;   // 200 MHz
  always #3.5 rclk = ~rclk;

  logic          wr_en = 1'b0, rd_en = 1'b0, off_we = 1'b0, off_sel = 1'b0;
  logic [17:0]   wr_data = '0;
  logic [AW-1:0] off_val = '0;
  logic [17:0]   rd_data_o;
  logic full_no, afull_w_no, aempty_w_no, empty_no, aempty_r_no, afull_r_no;

  xclk_flag_fifo #(.DEPTH(D)) u_xclk_flag_fifo (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .off_we_i(off_we), .off_sel_i(off_sel), .off_val_i(off_val),
    .full_no(full_no), .afull_w_no(afull_w_no), .aempty_w_no(aempty_w_no),
    .rd_en_i(rd_en), .rd_data_o(rd_data_o),
    .empty_no(empty_no), .aempty_r_no(aempty_r_no), .afull_r_no(afull_r_no)
  );

  int checks = 0, fails = 0;
  bit done = 0, inv_on = 0;
  int n_off = 8, m_off = 8;
  int rc, wc;
  logic [17:0] q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int cnt, input int pct);
    for (int i = 0; i < cnt; i++) begin
      bit acc;
      logic [17:0] d;
      @(negedge wclk);
      d = 18'($urandom);
      wr_data = d;
      wr_en = (($urandom % 100) < pct);
      acc = wr_en && full_no;
      @(posedge wclk);
      if (acc) q.push_back(d);
    end
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic wr_traffic(input int total, input int pct);
    int got = 0;
    while (got < total) begin
      bit acc;
      logic [17:0] d;
      @(negedge wclk);
      d = 18'($urandom);
      wr_data = d;
      wr_en = (($urandom % 100) < pct);
      acc = wr_en && full_no;
      @(posedge wclk);
      if (acc) begin q.push_back(d); got++; end
    end
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  // reads until 'total' words accepted (or 'tries' cycles if total<0)
  task automatic rd_run(input int total, input int tries, input int pct, input string tag);
    int got = 0, cyc = 0;
    bit pend = 0;
    logic [17:0] pexp = '0;
    while ((total >= 0) ? (got < total) : (cyc < tries)) begin
      bit acc;
      @(negedge rclk);
      if (pend) chk(rd_data_o == pexp, tag, int'(rd_data_o), int'(pexp));
      rd_en = (($urandom % 100) < pct);
      acc = rd_en && empty_no;
      @(posedge rclk);
      pend = acc;
      if (acc) begin pexp = q.pop_front(); got++; end
      cyc++;
    end
    @(negedge rclk);
    if (pend) chk(rd_data_o == pexp, tag, int'(rd_data_o), int'(pexp));
    rd_en = 1'b0;
  endtask

  task automatic load_off(input bit sel, input int val);
    @(negedge wclk);
    off_we = 1'b1; off_sel = sel; off_val = AW'(val);
    @(negedge wclk);
    off_we = 1'b0;
    if (sel) m_off = val; else n_off = val;
  endtask

  task automatic settle(input string tag);
    int c;
    repeat (8) @(negedge rclk);
    @(negedge wclk);
    c = q.size();
    chk(empty_no == (c != 0), {"R5 empty_no ", tag}, int'(empty_no), int'(c != 0));
    chk(aempty_r_no == (c > n_off), {"R6 aempty_r_no ", tag}, int'(aempty_r_no), int'(c > n_off));
    chk(aempty_w_no == (c > n_off), {"R6 aempty_w_no ", tag}, int'(aempty_w_no), int'(c > n_off));
    chk(afull_r_no == (c < D - m_off), {"R7 afull_r_no ", tag}, int'(afull_r_no), int'(c < D - m_off));
    chk(afull_w_no == (c < D - m_off), {"R7 afull_w_no ", tag}, int'(afull_w_no), int'(c < D - m_off));
    chk(full_no == (c != D), {"R8 full_no ", tag}, int'(full_no), int'(c != D));
  endtask

  // R9: one-sided bounds checked on every edge while traffic runs
  always @(negedge rclk) if (inv_on) begin
    rc = q.size();
    chk(!(rc == 0 && empty_no), "R9 empty_no high with no data", int'(empty_no), 0);
    chk(!(rc <= n_off && aempty_r_no), "R9 aempty_r_no high at/below n", int'(aempty_r_no), 0);
    chk(!(!afull_r_no && rc < D - m_off), "R9 afull_r_no low below D-m", rc, D - m_off);
  end

  always @(negedge wclk) if (inv_on) begin
    wc = q.size();
    chk(!(wc == D && full_no), "R9 full_no high at D", int'(full_no), 0);
    chk(!(wc >= D - m_off && afull_w_no), "R9 afull_w_no high at/above D-m", int'(afull_w_no), 0);
    chk(!(!aempty_w_no && wc > n_off), "R9 aempty_w_no low above n", wc, n_off);
  end

  initial begin
    logic [17:0] hold;
    repeat (3) @(negedge wclk);
    chk(rd_data_o == 18'd0, "R2 rd_data_o in reset", int'(rd_data_o), 0);
    rst_n = 1'b1;
    @(negedge rclk);
    chk(!empty_no && !aempty_r_no && afull_r_no, "R2 read-side flags after reset",
        {empty_no, aempty_r_no, afull_r_no}, 3'b001);
    chk(!aempty_w_no && afull_w_no && full_no, "R2 write-side flags after reset",
        {aempty_w_no, afull_w_no, full_no}, 3'b011);
    settle("R2 reset");

    push(1, 100);   settle("one word");
    push(7, 100);   settle("R2 default n=8 at 8");
    push(1, 100);   settle("R2 default n=8 at 9");
    push(238, 100); settle("at D-m-1");
    push(1, 100);   settle("R2 default m=8 at D-m");
    push(7, 100);   settle("at D-1");
    push(1, 100);   settle("at D");
    push(3, 100);   settle("R3 writes while full");
    chk(!full_no, "R3 still full after ignored writes", int'(full_no), 0);
    rd_run(256, 0, 100, "R1 R3 drain order");
    settle("drained");

    hold = rd_data_o;
    rd_run(-1, 4, 100, "R4 read while empty");
    chk(rd_data_o == hold, "R4 rd_data_o held on empty read", int'(rd_data_o), int'(hold));
    settle("R4 after empty reads");
    push(1, 100);
    rd_run(1, 0, 100, "R4 R1 pointer unmoved");
    settle("R4 after refill");

    load_off(1'b0, 3);
    load_off(1'b1, 5);
    push(3, 100);   settle("R10 n=3 at 3");
    push(1, 100);   settle("R10 n=3 at 4");
    push(246, 100); settle("R10 m=5 at D-m-1");
    push(1, 100);   settle("R10 m=5 at D-m");
    push(5, 100);   settle("R10 at D");
    rd_run(256, 0, 100, "R1 drain with loaded offsets");
    settle("R10 drained");

    inv_on = 1;
    fork
      wr_traffic(500, 90);
      rd_run(500, 0, 35, "R1 traffic fill-heavy");
    join
    fork
      wr_traffic(400, 35);
      rd_run(400, 0, 90, "R1 traffic drain-heavy");
    join
    inv_on = 0;
    settle("after traffic");

    push(20, 100);
    @(negedge wclk);
    rst_n = 1'b0;
    q.delete();
    n_off = 8; m_off = 8;
    repeat (2) @(negedge wclk);
    rst_n = 1'b1;
    settle("R2 reset mid-fill");
    push(9, 100); settle("R2 offsets back to 8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule